// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block is one DMA channel engine. A host loads a channel descriptor: the last source address, the last destination address and a 32-bit control word. After a separate enable, a request starts the channel. The engine then moves items as read/write pairs on a simple memory bus. It derives each address from the end pointer and the number of items still to move.

Items are moved in groups of 2^R. After each group the engine pulses a release output, so that a bus arbiter above it can hand the bus to someone else. In basic mode every group needs a fresh request. In auto mode the transfer runs to the end once started. On the last item the engine rewrites its control word to the stop mode, drops its own enable and pulses `done`. Illegal configurations raise `err` without touching the bus.

Top module: `dmaseq_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine returns to idle. It then shows `bus_valid`=0, `chan_en`=0, `remaining`=0, `done`=0, `grp_rel`=0 and `err`=0.
- R2: A `desc_load` pulse in idle captures the three words. `ctrl_out` then equals the loaded control word, and `remaining` equals control bits 13:4 plus one. Apart from a load, `remaining` never increases.
- R3: Bits 27:26 hold the source increment code and bits 31:30 the destination increment code (0=1 byte, 1=2, 2=4, 3=none). The address of an item is the end address minus (remaining−1) shifted left by the increment code. With code 3 it is the end address unchanged.
- R4: Reads use the source size in bits 25:24, and writes use the destination size in bits 29:28, with 0=8, 1=16 and 2=32 bits. The size code appears on `bus_size`.
- R5: Each item is one read cycle followed in the next cycle by one write. The write carries the data returned on `bus_rdata`, so the destination receives a copy of the source.
- R6: `grp_rel` pulses once after every 2^R items, where R is bits 17:14 limited to 10, and once after the final item. A burst or software request covers a whole group.
- R7: Basic mode (bits 2:0 = 1): after a group that leaves items pending, no bus access occurs until a new request arrives.
- R8: Auto mode (bits 2:0 = 2): after a single request, all groups run to completion with no further request.
- R9: After the final item, `done` pulses for one cycle. At the same time control bits 2:0 and 13:4 read 0, `remaining`=0 and `chan_en`=0. Further requests cause no bus access until a fresh enable.
- R10: With `req_mask`=1, `burst_req` and `single_req` are ignored, while `sw_req` still starts the channel.
- R11: With `use_burst`=0, a `single_req` in basic mode moves exactly one item. With `use_burst`=1, `single_req` is ignored.
- R12: A request sets `err` and clears `chan_en`, with no bus access, in any of these cases: an increment code below its size code, an end address misaligned for its size, or mode 3 to 7.
- R13: After a group that leaves items pending, control bits 13:4 read `remaining` minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_load | input | 1 | Load descriptor words (idle only) |
| desc_src_end | input | ADDR_W | Last source address |
| desc_dst_end | input | ADDR_W | Last destination address |
| desc_ctrl | input | 32 | Control word |
| en_set | input | 1 | Set the channel enable |
| sw_req | input | 1 | Software request, never masked |
| burst_req | input | 1 | Hardware group request |
| single_req | input | 1 | Hardware single-item request |
| req_mask | input | 1 | Ignore hardware requests |
| use_burst | input | 1 | Ignore single-item requests |
| bus_valid | output | 1 | Bus access this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | DATA_W | Write data, right aligned |
| bus_rdata | input | DATA_W | Read data, valid the cycle after a read |
| chan_en | output | 1 | Channel enable state |
| ctrl_out | output | 32 | Current control word with write-back |
| remaining | output | CNT_W | Items still to move |
| grp_rel | output | 1 | Bus released after a group |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Configuration error, held until next load |

## Verification
A wrong remaining count is visible at once on `remaining`, and also in the address of the very next bus access, because every address is derived from that count. A group counter that is off shows up on `grp_rel` at the wrong cycle within one group, and the bench counts those pulses against the expected number of groups. A sequencing fault shows within a cycle as a write with no read before it, or as bus traffic while `err` is set. A completion fault shows as a destination image that differs from the reference copy of the source.

// File: rtl/dmaseq_pkg.sv
// Shared types for the DMA channel sequencer.
// Assumes a 32-bit control word with fixed field positions.
package dmaseq_pkg;
    localparam logic [2:0] MODE_STOP  = 3'd0;
    localparam logic [2:0] MODE_BASIC = 3'd1;
    localparam logic [2:0] MODE_AUTO  = 3'd2;
    localparam logic [1:0] INC_NONE   = 2'd3;
    localparam logic [3:0] ARB_MAX    = 4'd10;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_ARB} seq_state_t;

    typedef struct packed {
        logic [1:0] dst_inc;
        logic [1:0] dst_size;
        logic [1:0] src_inc;
        logic [1:0] src_size;
        logic [3:0] arb_log2;
        logic [2:0] mode;
    } ctrl_fields_t;
endpackage

// File: rtl/dmaseq_decode.sv
// Control-word checker: derives the group size and flags illegal settings.
// Assumes fields are already split out; only address bits 1:0 matter.
module dmaseq_decode
    import dmaseq_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  ctrl_fields_t     fields,
    input  logic [1:0]       src_lo,
    input  logic [1:0]       dst_lo,
    output logic [CNT_W-1:0] grp_size,
    output logic             cfg_err
);
    logic [3:0] arb_eff;
    logic       bad_inc, bad_align, bad_mode;

    // Group size is 2^R with R limited to the legal maximum.
    always_comb begin
        arb_eff  = (fields.arb_log2 > ARB_MAX) ? ARB_MAX : fields.arb_log2;
        grp_size = CNT_W'(1) << arb_eff;
    end

    // Configuration legality: increment vs size, alignment, supported mode.
    always_comb begin
        bad_inc   = (fields.src_inc != INC_NONE && fields.src_inc < fields.src_size) ||
                    (fields.dst_inc != INC_NONE && fields.dst_inc < fields.dst_size);
        bad_align = (fields.src_size == 2'd3) || (fields.dst_size == 2'd3) ||
                    (fields.src_size == 2'd1 && src_lo[0]) ||
                    (fields.src_size == 2'd2 && src_lo != 2'd0) ||
                    (fields.dst_size == 2'd1 && dst_lo[0]) ||
                    (fields.dst_size == 2'd2 && dst_lo != 2'd0);
        bad_mode  = !(fields.mode == MODE_STOP || fields.mode == MODE_BASIC ||
                      fields.mode == MODE_AUTO);
        cfg_err   = bad_inc || bad_align || bad_mode;
    end
endmodule

// File: rtl/dmaseq_addr.sv
// Current-address generator: end pointer minus (remaining-1) << increment.
// Assumes remaining is at least one whenever the address is used.
module dmaseq_addr
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 11
) (
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [1:0]        inc,
    input  logic [CNT_W-1:0]  remaining,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] back_off;

    // Distance back from the end address for the next item.
    always_comb begin
        back_off = ADDR_W'(remaining - 1'b1) << inc;
        cur_addr = (inc == INC_NONE) ? end_addr : end_addr - back_off;
    end
endmodule

// File: rtl/dmaseq_engine.sv
// Single-channel DMA sequencer. Loads a descriptor, waits for enable and a
// request, then moves items as read/write pairs in groups of 2^R.
// Assumes the memory returns read data one cycle after a read and never stalls.
module dmaseq_engine
    import dmaseq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_ITEMS = 1024,
    localparam int CNT_W    = $clog2(MAX_ITEMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_src_end,
    input  logic [ADDR_W-1:0] desc_dst_end,
    input  logic [31:0]       desc_ctrl,
    input  logic              en_set,
    input  logic              sw_req,
    input  logic              burst_req,
    input  logic              single_req,
    input  logic              req_mask,
    input  logic              use_burst,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              chan_en,
    output logic [31:0]       ctrl_out,
    output logic [CNT_W-1:0]  remaining,
    output logic              grp_rel,
    output logic              done,
    output logic              err
);
    seq_state_t        state_q;
    logic [31:0]       ctrl_q;
    logic [ADDR_W-1:0] src_end_q, dst_end_q, src_cur, dst_cur;
    logic [CNT_W-1:0]  remaining_q, grp_left_q, grp_size;
    logic              chan_en_q, grp_rel_q, done_q, err_q, cfg_err;
    logic              hw_burst, hw_single, trigger, full_grp;
    ctrl_fields_t      fields;

    // Split the stored control word into its fields.
    always_comb begin
        fields.dst_inc  = ctrl_q[31:30];
        fields.dst_size = ctrl_q[29:28];
        fields.src_inc  = ctrl_q[27:26];
        fields.src_size = ctrl_q[25:24];
        fields.arb_log2 = ctrl_q[17:14];
        fields.mode     = ctrl_q[2:0];
    end

    dmaseq_decode #(.CNT_W(CNT_W)) decode_i (
        .fields(fields), .src_lo(src_end_q[1:0]), .dst_lo(dst_end_q[1:0]),
        .grp_size(grp_size), .cfg_err(cfg_err)
    );

    dmaseq_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) src_addr_i (
        .end_addr(src_end_q), .inc(fields.src_inc),
        .remaining(remaining_q), .cur_addr(src_cur)
    );

    dmaseq_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dst_addr_i (
        .end_addr(dst_end_q), .inc(fields.dst_inc),
        .remaining(remaining_q), .cur_addr(dst_cur)
    );

    // Request qualification: mask, burst-only attribute, enable and mode.
    always_comb begin
        hw_burst  = burst_req && !req_mask;
        hw_single = single_req && !req_mask && !use_burst;
        trigger   = chan_en_q && (fields.mode != MODE_STOP) &&
                    (sw_req || hw_burst || hw_single);
        full_grp  = sw_req || hw_burst || (fields.mode == MODE_AUTO);
    end

    // Sequencer state, counters, write-back and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ctrl_q      <= '0;
            src_end_q   <= '0;
            dst_end_q   <= '0;
            remaining_q <= '0;
            grp_left_q  <= '0;
            chan_en_q   <= 1'b0;
            grp_rel_q   <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            grp_rel_q <= 1'b0;
            done_q    <= 1'b0;
            if (en_set) chan_en_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (desc_load) begin
                        ctrl_q      <= desc_ctrl;
                        src_end_q   <= desc_src_end;
                        dst_end_q   <= desc_dst_end;
                        remaining_q <= CNT_W'(desc_ctrl[13:4]) + 1'b1;
                        err_q       <= 1'b0;
                    end else if (trigger) begin
                        if (cfg_err) begin
                            err_q     <= 1'b1;
                            chan_en_q <= 1'b0;
                        end else if (remaining_q != '0) begin
                            grp_left_q <= full_grp ? grp_size : CNT_W'(1);
                            state_q    <= ST_RD;
                        end
                    end
                end
                ST_RD: state_q <= ST_WR;
                ST_WR: begin
                    remaining_q <= remaining_q - 1'b1;
                    grp_left_q  <= grp_left_q - 1'b1;
                    if (remaining_q == CNT_W'(1)) begin
                        ctrl_q[2:0]  <= MODE_STOP;
                        ctrl_q[13:4] <= '0;
                        chan_en_q    <= 1'b0;
                        done_q       <= 1'b1;
                        grp_rel_q    <= 1'b1;
                        state_q      <= ST_IDLE;
                    end else if (grp_left_q == CNT_W'(1)) begin
                        grp_rel_q    <= 1'b1;
                        ctrl_q[13:4] <= 10'(remaining_q - CNT_W'(2));
                        state_q      <= (fields.mode == MODE_AUTO) ? ST_ARB : ST_IDLE;
                    end else begin
                        state_q <= ST_RD;
                    end
                end
                ST_ARB: begin
                    grp_left_q <= grp_size;
                    state_q    <= ST_RD;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus drive: read from source, then write the returned data to destination.
    always_comb begin
        bus_valid = (state_q == ST_RD) || (state_q == ST_WR);
        bus_write = (state_q == ST_WR);
        bus_addr  = bus_write ? dst_cur : src_cur;
        bus_size  = bus_write ? fields.dst_size : fields.src_size;
        bus_wdata = bus_rdata;
    end

    assign chan_en   = chan_en_q;
    assign ctrl_out  = ctrl_q;
    assign remaining = remaining_q;
    assign grp_rel   = grp_rel_q;
    assign done      = done_q;
    assign err       = err_q;
endmodule

// File: rtl/dmaseq_engine_chk.sv
// Protocol checker for the DMA channel sequencer, bound to the top module.
// Assumes synchronous active-low reset.
module dmaseq_engine_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             done,
    input logic             grp_rel,
    input logic             chan_en,
    input logic             err,
    input logic             desc_load,
    input logic [CNT_W-1:0] remaining
);
    // R5
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |-> $past(bus_valid && !bus_write));

    // R9
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!chan_en && remaining == '0));

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> grp_rel);

    // R12
    err_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_valid);

    // R2
    remaining_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(desc_load) |-> (remaining <= $past(remaining)));
endmodule

bind dmaseq_engine dmaseq_engine_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .done(done), .grp_rel(grp_rel), .chan_en(chan_en), .err(err),
    .desc_load(desc_load), .remaining(remaining)
);

// File: tb/dmaseq_engine_tb_top.sv
// Directed bench for the DMA channel sequencer with a byte memory model.
module dmaseq_engine_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        desc_load = 0, en_set = 0, sw_req = 0, burst_req = 0, single_req = 0;
    logic        req_mask = 0, use_burst = 0;
    logic [31:0] desc_src_end = 0, desc_dst_end = 0, desc_ctrl = 0;
    logic        bus_valid, bus_write, chan_en, grp_rel, done, err;
    logic [31:0] bus_addr, bus_wdata, ctrl_out;
    logic [31:0] bus_rdata = 0;
    logic [1:0]  bus_size;
    logic [10:0] remaining;

    int nchk = 0, nfail = 0;
    int rd_n = 0, wr_n = 0, rel_n = 0, done_n = 0;
    logic [31:0] first_rd, first_wr, last_wr;
    logic [7:0]  mem [0:4095];
    bit          finished = 0;

    always #10 clk = ~clk;

    dmaseq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_src_end(desc_src_end),
        .desc_dst_end(desc_dst_end), .desc_ctrl(desc_ctrl), .en_set(en_set),
        .sw_req(sw_req), .burst_req(burst_req), .single_req(single_req),
        .req_mask(req_mask), .use_burst(use_burst), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_en(chan_en),
        .ctrl_out(ctrl_out), .remaining(remaining), .grp_rel(grp_rel),
        .done(done), .err(err)
    );

    // Memory model: right-aligned data, read data one cycle later.
    always @(posedge clk) begin
        if (bus_valid) begin
            if (bus_write) begin
                for (int b = 0; b < (1 << bus_size); b++)
                    mem[12'(bus_addr + b)] <= bus_wdata[8*b +: 8];
            end else begin
                logic [31:0] v;
                v = '0;
                for (int b = 0; b < (1 << bus_size); b++)
                    v[8*b +: 8] = mem[12'(bus_addr + b)];
                bus_rdata <= v;
            end
        end
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid && !bus_write) begin
                if (rd_n == 0) first_rd = bus_addr;
                rd_n++;
            end
            if (bus_valid && bus_write) begin
                if (wr_n == 0) first_wr = bus_addr;
                last_wr = bus_addr;
                wr_n++;
            end
            if (grp_rel) rel_n++;
            if (done) done_n++;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int dinc, dsz, sinc, ssz, arb, n, mode);
        return {2'(dinc), 2'(dsz), 2'(sinc), 2'(ssz), 6'd0, 4'(arb), 10'(n - 1), 1'b0, 3'(mode)};
    endfunction

    task automatic clr_mon();
        rd_n = 0; wr_n = 0; rel_n = 0; done_n = 0;
    endtask

    task automatic load(input logic [31:0] s, d, c);
        @(negedge clk);
        desc_src_end = s; desc_dst_end = d; desc_ctrl = c; desc_load = 1;
        @(negedge clk);
        desc_load = 0; en_set = 1;
        @(negedge clk);
        en_set = 0;
        clr_mon();
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && done_n == 0; i++) @(negedge clk);
    endtask

    task automatic cmp_bytes(input string tag, input int s, d, n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[12'(s + i)] !== mem[12'(d + i)]) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 bus_valid", bus_valid, 0);
        chk("R1 chan_en", chan_en, 0);
        chk("R1 remaining", remaining, 0);
        chk("R1 done", done, 0);
        chk("R1 grp_rel", grp_rel, 0);
        chk("R1 err", err, 0);
    endtask

    // Basic byte copy, 8 items in groups of 4, one burst per group.
    task automatic t_basic();
        logic [31:0] c;
        c = mk_ctrl(0, 0, 0, 0, 2, 8, 1);
        load(32'h107, 32'h207, c);
        chk("R2 ctrl_out", ctrl_out, c);
        chk("R2 remaining", remaining, 8);
        pulse(burst_req);
        idle(15);
        chk("R7 reads after group", rd_n, 4);
        chk("R6 release after group", rel_n, 1);
        chk("R13 count field", ctrl_out[13:4], 3);
        chk("R3 first src addr", first_rd, 32'h100);
        idle(10);
        chk("R7 no access without request", rd_n, 4);
        chk("R7 remaining held", remaining, 4);
        pulse(burst_req);
        wait_done();
        chk("R9 done", done_n, 1);
        chk("R9 mode stop", ctrl_out[2:0], 0);
        chk("R9 count field", ctrl_out[13:4], 0);
        chk("R9 remaining", remaining, 0);
        chk("R9 chan_en", chan_en, 0);
        chk("R6 releases", rel_n, 2);
        cmp_bytes("R5 basic copy", 32'h100, 32'h200, 8);
        pulse(burst_req);
        idle(6);
        chk("R9 no access after done", rd_n, 8);
    endtask

    // Auto word copy, 5 items in groups of 2, one software request.
    task automatic t_auto();
        load(32'h310, 32'h410, mk_ctrl(2, 2, 2, 2, 1, 5, 2));
        pulse(sw_req);
        wait_done();
        chk("R8 all items", wr_n, 5);
        chk("R6 releases", rel_n, 3);
        chk("R3 first src addr", first_rd, 32'h300);
        chk("R3 first dst addr", first_wr, 32'h400);
        cmp_bytes("R4 word copy", 32'h300, 32'h400, 20);
    endtask

    // Halfword to a fixed destination, 4 items, group larger than transfer.
    task automatic t_noinc();
        load(32'h486, 32'h500, mk_ctrl(3, 1, 1, 1, 3, 4, 2));
        pulse(sw_req);
        wait_done();
        chk("R3 first src addr", first_rd, 32'h480);
        chk("R3 fixed dst first", first_wr, 32'h500);
        chk("R3 fixed dst last", last_wr, 32'h500);
        chk("R6 single release", rel_n, 1);
        chk("R4 last halfword", {mem[12'h501], mem[12'h500]}, {mem[12'h487], mem[12'h486]});
    endtask

    // Hardware requests masked, software request still starts.
    task automatic t_mask();
        req_mask = 1;
        load(32'h601, 32'h681, mk_ctrl(0, 0, 0, 0, 1, 2, 1));
        pulse(burst_req);
        pulse(single_req);
        idle(6);
        chk("R10 masked no reads", rd_n, 0);
        chk("R10 remaining held", remaining, 2);
        pulse(sw_req);
        wait_done();
        req_mask = 0;
        chk("R10 sw done", done_n, 1);
        cmp_bytes("R10 copy", 32'h600, 32'h680, 2);
    endtask

    // Single requests: ignored under use_burst, one item otherwise.
    task automatic t_single();
        use_burst = 1;
        load(32'h702, 32'h782, mk_ctrl(0, 0, 0, 0, 1, 3, 1));
        pulse(single_req);
        idle(6);
        chk("R11 single ignored", rd_n, 0);
        use_burst = 0;
        pulse(single_req);
        idle(6);
        chk("R11 one item", wr_n, 1);
        chk("R11 remaining", remaining, 2);
        chk("R13 count field", ctrl_out[13:4], 1);
        pulse(burst_req);
        wait_done();
        chk("R11 completes", wr_n, 3);
        cmp_bytes("R11 copy", 32'h700, 32'h780, 3);
    endtask

    task automatic t_err(input string tag, input logic [31:0] s, d, c);
        load(s, d, c);
        pulse(sw_req);
        idle(3);
        chk({tag, " err"}, err, 1);
        chk({tag, " chan_en"}, chan_en, 0);
        chk({tag, " no access"}, rd_n, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 13) + (i >> 8) + 1);
        for (int i = 0; i < 4096; i++) if (i >= 'h200 && i < 'h210) mem[i] = 8'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        idle(2);
        t_basic();
        t_auto();
        t_noinc();
        t_mask();
        t_single();
        t_err("R12 inc below size", 32'h810, 32'h910, mk_ctrl(2, 2, 0, 2, 0, 4, 1));
        t_err("R12 misaligned", 32'h812, 32'h910, mk_ctrl(2, 2, 2, 2, 0, 4, 1));
        t_err("R12 bad mode", 32'h810, 32'h910, mk_ctrl(0, 0, 0, 0, 0, 4, 3));
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule